// File: doc/BRIEF.md
# Double-Buffered IOM-2 Time-Slot Port

This block terminates one IOM-2 lane pair: a downstream serial output and an upstream serial input. It runs on the data clock and is framed by a one-cycle frame-start strobe. Within a frame, time slots of eight bits each travel most significant bit first. The frame holds 6, 12 or 32 slots. A double clock mode stretches every bit over two clock cycles.

The port keeps two receive banks and two transmit banks in a ping-pong arrangement. While the serial side fills one receive bank and drains one transmit bank, the processor reads the other receive bank and writes the other transmit bank. Both pairs change roles at every frame start. A processor therefore always reads the bytes of the last complete frame, and its writes go out in the next frame to start.

Output drive is controlled per slot by an enable mask. An open-drain option releases the line for every '1' bit. The tri-state is expressed as a data pin plus an output-enable pin, so the pad ring can build the actual buffer.

Top module: `iom2_pingpong_port`

## Requirements
- R1: `frame_mode` selects the slots per frame: 0 gives 6, 1 gives 12, 2 and 3 give 32. After the last bit of the last slot, `dd_oe` stays 0 until the next frame start.
- R2: When `fsc` is sampled high at a rising edge, that edge starts a frame. During the following cycle the port presents bit 7 of slot 0. Each slot then runs from bit 7 down to bit 0, and slots follow in increasing order.
- R3: With `dbl_clk`=0 every bit lasts one clock cycle. With `dbl_clk`=1 every bit lasts two clock cycles.
- R4: `ser_buf` names the bank used by the serial side. It toggles at every rising edge that samples `fsc` high and holds at all other edges.
- R5: `cpu_rdata` returns the byte received in slot `cpu_addr` during the last complete frame.
- R6: A byte written with `cpu_we`=1 to address k before a frame start is sent in slot k of the frame that this frame start begins.
- R7: When `slot_en[k]`=0, `dd_oe` is 0 for all of slot k.
- R8: With `od_mode`=1, `dd_oe` is 0 while a '1' bit is due. While a '0' bit is due in an enabled slot, `dd_oe` is 1 and `dd_out` is 0. With `od_mode`=0, `dd_out` carries the bit and `dd_oe` is 1 in enabled slots.
- R9: The port samples `du_in` on the falling clock edge. In double clock mode it samples on the falling edge of the second cycle of each bit and ignores `du_in` during the first cycle.
- R10: After reset, `dd_oe`=0, `ser_buf`=0, and both receive banks read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock; rising edge launches, falling edge samples |
| rst | input | 1 | Synchronous active-high reset |
| fsc | input | 1 | Frame-start strobe, one cycle high |
| dbl_clk | input | 1 | 1: two clock cycles per bit |
| frame_mode | input | 2 | Frame length select (6/12/32 slots) |
| od_mode | input | 1 | Open-drain downstream drive |
| slot_en | input | 32 | Per-slot downstream drive enable |
| du_in | input | 1 | Upstream serial data |
| dd_out | output | 1 | Downstream serial data value |
| dd_oe | output | 1 | Downstream drive enable (0 = high impedance) |
| cpu_addr | input | 5 | Processor slot address |
| cpu_we | input | 1 | Processor write strobe to the transmit bank |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rdata | output | 8 | Processor read byte from the receive bank |
| ser_buf | output | 1 | Index of the serial-side bank |

## Verification
The assertions check several rules on every cycle:
- the bank index flips exactly on frame starts and holds otherwise;
- the line is never driven outside a frame or in a masked slot;
- open-drain mode never drives a '1';
- in double clock mode the output holds across both cycles of a bit.

Other properties can only be shown by the bench's scenarios, because they depend on bytes that cross frame boundaries. These are the data order, the one-frame delay of both the read path and the write path, the second-cycle sampling of upstream bits, and the slot count of each frame length.

// File: rtl/iom2_port_pkg.sv
package iom2_port_pkg;

    localparam int MAX_SLOTS = 32;
    localparam int SLOT_W    = $clog2(MAX_SLOTS);
    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int NUM_BANKS = 2;

    typedef enum logic [1:0] {
        FMT_6   = 2'd0,
        FMT_12  = 2'd1,
        FMT_32  = 2'd2,
        FMT_32B = 2'd3
    } frame_fmt_e;

    typedef struct packed {
        logic              active;
        logic              phase;
        logic [BIT_W-1:0]  bit_idx;
        logic [SLOT_W-1:0] slot;
    } bit_pos_t;

    function automatic logic [SLOT_W-1:0] last_slot(frame_fmt_e fmt);
        case (fmt)
            FMT_6:   return SLOT_W'(5);
            FMT_12:  return SLOT_W'(11);
            default: return SLOT_W'(MAX_SLOTS - 1);
        endcase
    endfunction

endpackage

// File: rtl/iom2_frame_timer.sv
module iom2_frame_timer
    import iom2_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fsc,
    input  logic       dbl_clk,
    input  frame_fmt_e fmt,
    output bit_pos_t   pos,
    output logic       ser_sel
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic bit_done;
    assign bit_done = !dbl_clk || pos.phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            ser_sel <= 1'b0;
        end else if (fsc) begin
            pos.active  <= 1'b1;
            pos.phase   <= 1'b0;
            pos.bit_idx <= '0;
            pos.slot    <= '0;
            ser_sel     <= ~ser_sel;
        end else if (pos.active) begin
            if (!bit_done) begin
                pos.phase <= 1'b1;
            end else begin
                pos.phase   <= 1'b0;
                pos.bit_idx <= pos.bit_idx + 1'b1;
                if (pos.bit_idx == LAST_BIT) begin
                    pos.slot <= pos.slot + 1'b1;
                    if (pos.slot == last_slot(fmt))
                        pos.active <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/iom2_rx_capture.sv
module iom2_rx_capture
    import iom2_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              du_in,
    input  logic              dbl_clk,
    input  bit_pos_t          pos,
    input  logic              ser_sel,
    input  logic [SLOT_W-1:0] cpu_addr,
    output logic [BYTE_W-1:0] cpu_rdata
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

    logic              smp_vld;
    logic              smp_bit;
    logic              smp_last;
    logic              smp_sel;
    logic [SLOT_W-1:0] smp_slot;
    logic [BYTE_W-2:0] shreg;
    logic [BYTE_W-1:0] done_byte;
    logic [NUM_BANKS-1:0][BYTE_W-1:0] rd_byte;

    // falling-edge sampler: the bit is stable here, half a cycle after launch
    always_ff @(negedge clk) begin
        if (rst) begin
            smp_vld  <= 1'b0;
            smp_bit  <= 1'b0;
            smp_last <= 1'b0;
            smp_sel  <= 1'b0;
            smp_slot <= '0;
        end else begin
            smp_vld  <= pos.active && (!dbl_clk || pos.phase);
            smp_bit  <= du_in;
            smp_last <= (pos.bit_idx == LAST_BIT);
            smp_sel  <= ser_sel;
            smp_slot <= pos.slot;
        end
    end

    assign done_byte = {shreg, smp_bit};

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (smp_vld)
            shreg <= done_byte[BYTE_W-2:0];
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BYTE_W-1:0] mem [MAX_SLOTS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MAX_SLOTS; i++)
                    mem[i] <= '0;
            end else if (smp_vld && smp_last && (smp_sel == 1'(b))) begin
                mem[smp_slot] <= done_byte;
            end
        end

        assign rd_byte[b] = mem[cpu_addr];
    end

    assign cpu_rdata = rd_byte[~ser_sel];

endmodule

// File: rtl/iom2_tx_drive.sv
module iom2_tx_drive
    import iom2_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cpu_we,
    input  logic [SLOT_W-1:0]    cpu_addr,
    input  logic [BYTE_W-1:0]    cpu_wdata,
    input  bit_pos_t             pos,
    input  logic                 ser_sel,
    input  logic                 od_mode,
    input  logic [MAX_SLOTS-1:0] slot_en,
    output logic                 dd_out,
    output logic                 dd_oe
);

    logic [NUM_BANKS-1:0][BYTE_W-1:0] cur_byte;
    logic                             tx_bit;
    logic                             slot_drive;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BYTE_W-1:0] mem [MAX_SLOTS];

        // the processor only ever writes the bank the serial side is not reading
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MAX_SLOTS; i++)
                    mem[i] <= '0;
            end else if (cpu_we && (ser_sel != 1'(b))) begin
                mem[cpu_addr] <= cpu_wdata;
            end
        end

        assign cur_byte[b] = mem[pos.slot];
    end

    assign tx_bit     = cur_byte[ser_sel][BIT_W'(BYTE_W - 1) - pos.bit_idx];
    assign slot_drive = pos.active && slot_en[pos.slot];
    assign dd_oe      = slot_drive && (!od_mode || !tx_bit);
    assign dd_out     = od_mode ? 1'b0 : tx_bit;

endmodule

// File: rtl/iom2_pingpong_port.sv
module iom2_pingpong_port
    import iom2_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        fsc,
    input  logic        dbl_clk,
    input  logic [1:0]  frame_mode,
    input  logic        od_mode,
    input  logic [31:0] slot_en,
    input  logic        du_in,
    output logic        dd_out,
    output logic        dd_oe,
    input  logic [4:0]  cpu_addr,
    input  logic        cpu_we,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        ser_buf
);

    bit_pos_t pos;
    logic     ser_sel;

    iom2_frame_timer u_timer (
        .clk     (clk),
        .rst     (rst),
        .fsc     (fsc),
        .dbl_clk (dbl_clk),
        .fmt     (frame_fmt_e'(frame_mode)),
        .pos     (pos),
        .ser_sel (ser_sel)
    );

    iom2_rx_capture u_rx (
        .clk       (clk),
        .rst       (rst),
        .du_in     (du_in),
        .dbl_clk   (dbl_clk),
        .pos       (pos),
        .ser_sel   (ser_sel),
        .cpu_addr  (cpu_addr),
        .cpu_rdata (cpu_rdata)
    );

    iom2_tx_drive u_tx (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .pos       (pos),
        .ser_sel   (ser_sel),
        .od_mode   (od_mode),
        .slot_en   (slot_en),
        .dd_out    (dd_out),
        .dd_oe     (dd_oe)
    );

    assign ser_buf = ser_sel;

endmodule

// File: rtl/iom2_port_checker.sv
module iom2_port_checker
    import iom2_port_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        fsc,
    input logic        dbl_clk,
    input logic        od_mode,
    input logic [31:0] slot_en,
    input logic        dd_out,
    input logic        dd_oe,
    input logic        ser_buf,
    input bit_pos_t    cur_pos
);

    // R1: nothing is driven between frames
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !cur_pos.active |-> !dd_oe);

    // R4: bank roles flip on a frame start
    p_swap_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        fsc |=> (ser_buf != $past(ser_buf)));

    // R4: bank roles hold without a frame start
    p_hold_between_r4: assert property (@(posedge clk) disable iff (rst)
        !fsc |=> $stable(ser_buf));

    // R7: masked slots are never driven
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        dd_oe |-> slot_en[cur_pos.slot]);

    // R8: open drain never drives high
    p_od_low_only_r8: assert property (@(posedge clk) disable iff (rst)
        (od_mode && dd_oe) |-> !dd_out);

    // R3: in double clock mode a bit holds for both of its cycles
    p_dbl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (dbl_clk && cur_pos.active && !cur_pos.phase && !fsc) |=> $stable(dd_out));

endmodule

bind iom2_pingpong_port iom2_port_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .fsc     (fsc),
    .dbl_clk (dbl_clk),
    .od_mode (od_mode),
    .slot_en (slot_en),
    .dd_out  (dd_out),
    .dd_oe   (dd_oe),
    .ser_buf (ser_buf),
    .cur_pos (pos)
);

// File: tb/iom2_pingpong_port_tb_top.sv
module iom2_pingpong_port_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        fsc;
    logic        dbl_clk;
    logic [1:0]  frame_mode;
    logic        od_mode;
    logic [31:0] slot_en;
    logic        du_in;
    logic        dd_out;
    logic        dd_oe;
    logic [4:0]  cpu_addr;
    logic        cpu_we;
    logic [7:0]  cpu_wdata;
    logic [7:0]  cpu_rdata;
    logic        ser_buf;

    always #2 clk = ~clk;

    iom2_pingpong_port dut_i (
        .clk        (clk),
        .rst        (rst),
        .fsc        (fsc),
        .dbl_clk    (dbl_clk),
        .frame_mode (frame_mode),
        .od_mode    (od_mode),
        .slot_en    (slot_en),
        .du_in      (du_in),
        .dd_out     (dd_out),
        .dd_oe      (dd_oe),
        .cpu_addr   (cpu_addr),
        .cpu_we     (cpu_we),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .ser_buf    (ser_buf)
    );

    typedef struct {
        logic  oe;
        logic  out;
        bit    chk_out;
        string tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int        checks = 0;
    int        errors = 0;
    logic [7:0] tx_model [32];
    logic [7:0] rx_cur   [32];
    logic [7:0] rx_prev  [32];
    int         prev_slots = 32;
    logic       exp_sel = 1'b0;

    task automatic push_idle();
        exp_item_t e;
        e.oe = 1'b0; e.out = 1'b0; e.chk_out = 1'b0; e.tag = "R1";
        exp_q.push_back(e);
    endtask

    // monitor: compares the line every cycle, after the outputs have settled
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (exp_q.size() > 0) begin
                exp_item_t e;
                e = exp_q.pop_front();
                checks++;
                if (dd_oe !== e.oe) begin
                    errors++;
                    $display("FAIL %s dd_oe actual=%b expected=%b at %0t", e.tag, dd_oe, e.oe, $time);
                end else if (e.chk_out && (dd_out !== e.out)) begin
                    errors++;
                    $display("FAIL %s R6 dd_out actual=%b expected=%b at %0t", e.tag, dd_out, e.out, $time);
                end
            end
        end
    end

    task automatic run_frame(input logic [1:0] fmt, input bit dbl, input bit od,
                             input logic [31:0] mask);
        int slots;
        int ncyc;
        slots = (fmt == 2'd0) ? 6 : (fmt == 2'd1) ? 12 : 32;
        ncyc  = slots * 8 * (dbl ? 2 : 1);
        @(posedge clk); #1;
        frame_mode = fmt; dbl_clk = dbl; od_mode = od; slot_en = mask;
        push_idle();
        // R6: fill the processor-side transmit bank
        for (int a = 0; a < 32; a++) begin
            @(posedge clk); #1;
            tx_model[a] = 8'($urandom);
            rx_cur[a]   = 8'($urandom);
            cpu_we = 1'b1; cpu_addr = 5'(a); cpu_wdata = tx_model[a];
            push_idle();
        end
        @(posedge clk); #1;
        cpu_we = 1'b0; fsc = 1'b1;
        push_idle();
        exp_sel = ~exp_sel;
        for (int k = 0; k < ncyc; k++) begin
            int bt;
            int sl;
            int bi;
            bit first_half;
            logic bv;
            logic ub;
            exp_item_t e;
            @(posedge clk); #1;
            fsc = 1'b0;
            bt = dbl ? k / 2 : k;
            first_half = dbl && (k % 2 == 0);
            sl = bt / 8;
            bi = bt % 8;
            bv = tx_model[sl][7 - bi];
            ub = rx_cur[sl][7 - bi];
            // R9: wrong value in the first half of a doubled bit
            du_in = first_half ? ~ub : ub;
            e.oe      = mask[sl] && (!od || !bv);
            e.out     = od ? 1'b0 : bv;
            e.chk_out = e.oe;
            e.tag     = !mask[sl] ? "R7" : od ? "R8" : dbl ? "R3" : "R2";
            exp_q.push_back(e);
            if (k == 0) begin
                #2;
                checks++;
                if (ser_buf !== exp_sel) begin
                    errors++;
                    $display("FAIL R4 ser_buf actual=%b expected=%b", ser_buf, exp_sel);
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            du_in = 1'b0;
            push_idle();
        end
        // R5 R9: processor side now holds the frame before this one
        for (int a = 0; a < prev_slots; a++) begin
            @(posedge clk); #1;
            cpu_addr = 5'(a);
            push_idle();
            #2;
            checks++;
            if (cpu_rdata !== rx_prev[a]) begin
                errors++;
                $display("FAIL R5 R9 slot %0d cpu_rdata actual=%h expected=%h", a, cpu_rdata, rx_prev[a]);
            end
        end
        for (int a = 0; a < 32; a++) rx_prev[a] = rx_cur[a];
        prev_slots = slots;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; fsc = 1'b0; dbl_clk = 1'b0; frame_mode = 2'd0; od_mode = 1'b0;
        slot_en = '1; du_in = 1'b0; cpu_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
        for (int a = 0; a < 32; a++) rx_prev[a] = 8'h00;
        repeat (3) @(posedge clk);
        #3;
        // R10: reset state
        checks++;
        if (dd_oe !== 1'b0 || ser_buf !== 1'b0 || cpu_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R10 reset actual=%b%b%h expected=0000", dd_oe, ser_buf, cpu_rdata);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        run_frame(2'd0, 1'b0, 1'b0, 32'hFFFF_FFFF);
        run_frame(2'd1, 1'b0, 1'b0, 32'h0000_0A5B);
        run_frame(2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF);
        run_frame(2'd0, 1'b1, 1'b1, 32'h0000_0036);
        run_frame(2'd3, 1'b0, 1'b1, 32'hF0F0_FF0F);
        run_frame(2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF);
        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule